// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block takes a 16-bit frequency control word from a three-wire serial link (a serial clock, a data line and a latch strobe) and presents it as a parallel word to a tone synthesizer. The three serial lines are asynchronous to the system clock. Each one is synchronized into the system clock domain, and every action is triggered by an edge found there, never by a line's level.

Bits move into a shift register on each rising serial clock edge, least significant bit first. A falling strobe edge copies the register into a separate output latch and raises a one-cycle valid strobe. The latch holds its word while the next word is shifted in. The strobe has a second role. When the shift register holds all zeros and the strobe stays high for a set number of system cycles, the block raises a power-down flag. The next falling strobe edge clears that flag.

Top module: `freq_word_loader`

## Requirements
- R1: After reset, `word_o` is 0, `word_vld_o` is 0 and `pwr_dn_o` is 0.
- R2: After 16 rising edges of `ser_clk_i` and a falling edge of `ser_stb_i`, `word_o` holds the 16 shifted bits. The first bit shifted in is bit 0 and the last is bit 15.
- R3: While a new word is shifted in without a falling strobe edge, `word_o` keeps its previous value and `word_vld_o` stays 0.
- R4: Each falling edge of `ser_stb_i` gives exactly one `word_vld_o` pulse, one system cycle long. `word_o` takes the new value in the same cycle as the pulse, and `word_o` never changes in any other cycle.
- R5: Capture responds only to edges. A serial clock held high shifts exactly one bit: the value on the data line before the rise. Data changes while the clock is held high are ignored. A strobe held low causes no further latching.
- R6: If the shift register is all zeros and the synchronized strobe is high for HOLD_CYC consecutive system cycles, `pwr_dn_o` becomes 1. A strobe pulse shorter than that leaves `pwr_dn_o` at 0.
- R7: A strobe held high for any length of time while the shift register holds a nonzero value leaves `pwr_dn_o` at 0.
- R8: A falling strobe edge clears `pwr_dn_o`. In the same cycle it latches the shift register contents, which are zero in this case, and pulses `word_vld_o`.
- R9: A rising edge of `ser_stb_i` changes neither `word_o` nor `word_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| ser_stb_i | input | 1 | Latch strobe; a falling edge latches, a long high with zero data requests power-down |
| word_o | output | 16 | Latched frequency word |
| word_vld_o | output | 1 | One-cycle pulse when `word_o` is updated |
| pwr_dn_o | output | 1 | Power-down flag |

## Verification
The checks assume each serial line stays at one level for at least a few system cycles between changes, so that every edge is seen exactly once after synchronization. They also assume the data line is steady for at least two system cycles before a serial clock rise, and that the strobe falls only while the serial clock is low. The stimulus holds each serial clock phase and each strobe level for four or more system cycles. It changes data only while the clock is low, except in the one case that deliberately toggles data during a long high phase. The strobe always falls with the serial clock low.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SYNC_N = 3;
  localparam int unsigned IDX_DAT = 0;
  localparam int unsigned IDX_SCK = 1;
  localparam int unsigned IDX_STB = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fwl_sync.sv
module fwl_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prv_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g] = s2_q;
    assign prv_o[g] = s3_q;
  end
endmodule

// File: rtl/fwl_shift.sv
module fwl_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o,
  output logic         zero_o
);
  logic [W-1:0] sr_q;
  // first bit in ends at bit 0 after W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[W-1:1]};
  end
  assign sr_o   = sr_q;
  assign zero_o = (sr_q == '0);
endmodule

// File: rtl/fwl_ctrl.sv
module fwl_ctrl #(
  parameter int unsigned W        = 16,
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         stb_lvl_i,
  input  logic         zero_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] word_o,
  output logic         vld_o,
  output logic         pd_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  logic [W-1:0]     word_q;
  logic             vld_q, pd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) word_q <= sr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q  <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      pd_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!pd_q) begin
      if (stb_lvl_i && zero_i) begin
        if (cnt_q == CNT_LAST) begin
          pd_q  <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader
  import fwl_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  input  logic        ser_stb_i,
  output logic [15:0] word_o,
  output logic        word_vld_o,
  output logic        pwr_dn_o
);
  logic [SYNC_N-1:0] lvl, prv;
  logic              sck_rise, stb_fall, stb_lvl, sr_zero;
  word_t             sr;

  fwl_sync #(.N(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_stb_i, ser_clk_i, ser_dat_i}),
    .lvl_o   (lvl),
    .prv_o   (prv)
  );

  assign sck_rise = lvl[IDX_SCK] & ~prv[IDX_SCK];
  assign stb_fall = ~lvl[IDX_STB] & prv[IDX_STB];
  assign stb_lvl  = lvl[IDX_STB];

  // data taken one sample before the detected rise for hold margin
  fwl_shift #(.W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sck_rise),
    .bit_i   (prv[IDX_DAT]),
    .sr_o    (sr),
    .zero_o  (sr_zero)
  );

  fwl_ctrl #(.W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (stb_fall),
    .stb_lvl_i (stb_lvl),
    .zero_i    (sr_zero),
    .sr_i      (sr),
    .word_o    (word_o),
    .vld_o     (word_vld_o),
    .pd_o      (pwr_dn_o)
  );
endmodule

// File: rtl/fwl_chk.sv
module fwl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] word_o,
  input logic        word_vld_o,
  input logic        pwr_dn_o,
  input logic        stb_lvl,
  input logic        sr_zero
);
  assert_vld_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> $stable(word_o));

  assert_pd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> !pwr_dn_o);

  assert_pd_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_dn_o) |-> word_vld_o);

  assert_pd_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_dn_o) |-> $past(sr_zero && stb_lvl));
endmodule

bind freq_word_loader fwl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .pwr_dn_o   (pwr_dn_o),
  .stb_lvl    (stb_lvl),
  .sr_zero    (sr_zero)
);

// File: tb/sim_freq_word_loader.sv
`timescale 1ns/1ps
module sim_freq_word_loader;
  localparam int HOLD = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdat = 1'b0, sstb = 1'b0;
  logic [15:0] word;
  logic vld, pd;
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic vld_d = 1'b0;

  always #2.5 clk = ~clk;

  freq_word_loader #(.HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_dat_i(sdat),
    .ser_stb_i(sstb), .word_o(word), .word_vld_o(vld), .pwr_dn_o(pd)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b; wait_n(4);
    sck = 1'b1; wait_n(4);
    sck = 1'b0;
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send_bit(w[i]);
    wait_n(4);
  endtask

  task automatic latch(input logic [15:0] w, input string tag);
    sstb = 1'b1; wait_n(4);
    exp_q.push_back(w); tag_q.push_back(tag);
    sstb = 1'b0; wait_n(8);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld && vld_d) chk(1'b0, "R4 pulse longer than one cycle", {15'd0, vld}, 16'd0);
      if (vld && !vld_d) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected valid pulse", word, 16'hxxxx);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(word === e, t, word, e);
        end
      end
      vld_d <= vld;
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 16'd0, 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    wait_n(3);
    chk(word === 16'd0 && vld === 1'b0 && pd === 1'b0, "R1 state during reset", word, 16'd0);
    rst_n = 1'b1;
    wait_n(4);
    chk(word === 16'd0 && vld === 1'b0 && pd === 1'b0, "R1 state after reset", word, 16'd0);

    // R2 bit order, several patterns
    shift_word(16'hA5C3); latch(16'hA5C3, "R2 word A5C3");
    shift_word(16'h0001); latch(16'h0001, "R2 first bit is bit 0");
    shift_word(16'h8000); latch(16'h8000, "R2 last bit is bit 15");
    chk(pd === 1'b0, "R2 no power-down on data", {15'd0, pd}, 16'd0);

    // R3 double buffering
    shift_word(16'h1234);
    wait_n(20);
    chk(word === 16'h8000, "R3 latch holds during shift", word, 16'h8000);
    latch(16'h1234, "R3 new word after strobe");

    // R5 clock held high, data toggled during high phase
    w = 16'h5A0F;
    for (int i = 0; i < 16; i++) begin
      if (i == 5) begin
        sdat = w[i]; wait_n(4);
        sck = 1'b1; wait_n(2);
        sdat = ~w[i]; wait_n(30);
        sck = 1'b0; sdat = w[i];
      end else send_bit(w[i]);
    end
    wait_n(4);
    latch(w, "R5 long clock high shifts once");
    wait_n(40);
    chk(word === w, "R5 strobe low keeps word", word, w);

    // R9 strobe rise has no effect
    shift_word(16'hBEEF);
    sstb = 1'b1; wait_n(10);
    chk(word === w, "R9 strobe rise leaves word", word, w);
    exp_q.push_back(16'hBEEF); tag_q.push_back("R9 latch after rise");
    sstb = 1'b0; wait_n(8);

    // R7 nonzero data with long strobe high
    shift_word(16'h00F0);
    sstb = 1'b1; wait_n(40);
    chk(pd === 1'b0, "R7 nonzero data no power-down", {15'd0, pd}, 16'd0);
    exp_q.push_back(16'h00F0); tag_q.push_back("R7 latch after long high");
    sstb = 1'b0; wait_n(8);

    // R6 short strobe with zero data: no power-down
    shift_word(16'h0000);
    latch(16'h0000, "R6 short strobe latches zero");
    chk(pd === 1'b0, "R6 short strobe no power-down", {15'd0, pd}, 16'd0);

    // R6 long strobe with zero data
    sstb = 1'b1; wait_n(3);
    chk(pd === 1'b0, "R6 not yet in power-down", {15'd0, pd}, 16'd0);
    wait_n(30);
    chk(pd === 1'b1, "R6 power-down entered", {15'd0, pd}, 16'd1);
    wait_n(20);
    chk(pd === 1'b1, "R6 power-down held", {15'd0, pd}, 16'd1);

    // R8 exit
    exp_q.push_back(16'h0000); tag_q.push_back("R8 exit latches zero");
    sstb = 1'b0; wait_n(8);
    chk(pd === 1'b0, "R8 power-down cleared", {15'd0, pd}, 16'd0);

    // normal operation resumes
    shift_word(16'hC001); latch(16'hC001, "R2 word after power-down");

    wait_n(10);
    chk(exp_q.size() == 0, "R4 missing valid pulses", 16'(exp_q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule